// File: doc/BRIEF.md
# Sample Port Router

This block takes a stream of fixed-width samples, at most one per clock, and distributes it over two output ports, A and B, while producing a data clock that downstream logic uses to capture those ports. Three static configuration pins choose the operating mode. The first chooses full rate or a divided rate. The second chooses a divide-by-2 or a divide-by-N group when the rate is divided. The third chooses whether both ports carry identical data.

The modes are as follows. At full rate, port A alone can follow the stream, or both ports can follow it. At half rate, the block can act as a 1:2 demultiplexer, with the newest sample on A and the one before it on B. It can also keep only every second sample and copy it to both ports. At the slow rate, only the last sample of each group of N is kept, on A alone or on both ports.

A port that a mode leaves unused holds its last value and drops its active flag. Whenever the configuration changes, the block starts a fresh group. It emits nothing until that group is complete.

Top module: `sample_port_router`

## Requirements
- R1: While rst_n is low, port_a_o, port_b_o, a_act_o, b_act_o and dclk_o are all 0.
- R2: With cfg_div_i=0 and cfg_dup_i=0, port_a_o shows each accepted sample from the clock edge that accepts it. port_b_o is not updated. cfg_mod_i has no effect.
- R3: With cfg_div_i=0 and cfg_dup_i=1, both ports show each accepted sample from the edge that accepts it, whatever cfg_mod_i is.
- R4: With cfg_div_i=1, cfg_mod_i=0, cfg_dup_i=0, the ports update on every 2nd accepted sample. port_a_o takes that sample and port_b_o takes the sample accepted just before it.
- R5: With cfg_div_i=1, cfg_mod_i=0, cfg_dup_i=1, both ports take every 2nd accepted sample. The sample between two updates is dropped.
- R6: With cfg_div_i=1, cfg_mod_i=1, cfg_dup_i=0, port_a_o takes the last sample of each group of DEC_SLOW accepted samples. The others are dropped and port_b_o is not updated.
- R7: With cfg_div_i=1, cfg_mod_i=1, cfg_dup_i=1, both ports take the last sample of each group of DEC_SLOW accepted samples.
- R8: From the first edge after reset, a_act_o is 1. b_act_o equals cfg_dup_i | (cfg_div_i & ~cfg_mod_i), registered one edge later. While b_act_o is 0, port_b_o keeps its value.
- R9: At the edge where the configuration pins first differ from the previous edge, the sample is dropped and grouping restarts. The first update in the new mode comes only after a full group of accepted samples. Until then both ports keep their old values.
- R10: With a continuous stream, dclk_o behaves as follows. At full rate it equals clk. At half rate it is high one clock period and low one clock period. At the slow rate it is high and low for DEC_SLOW/2 clock periods each; for odd DEC_SLOW this uses half periods.
- R11: In the divided modes, a port update happens only at the clk rising edge where dclk_o rises. dclk_o is high in the half period after every update.
- R12: A clock with smp_vld_i=0 accepts no sample and does not advance grouping or update any port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_i | input | SAMPLE_W | Incoming sample |
| smp_vld_i | input | 1 | Sample present this clock |
| cfg_div_i | input | 1 | 1 selects a divided rate |
| cfg_mod_i | input | 1 | With cfg_div_i=1: 0 halves the rate, 1 divides it by DEC_SLOW |
| cfg_dup_i | input | 1 | 1 drives identical data on both ports |
| port_a_o | output | SAMPLE_W | Port A data |
| port_b_o | output | SAMPLE_W | Port B data |
| a_act_o | output | 1 | Port A in use |
| b_act_o | output | 1 | Port B in use |
| dclk_o | output | 1 | Output data clock |

## Verification
The bench drives a counting sample stream through all six modes and a mode that only differs in the ignored pin. It predicts, from the sample count since each configuration change, which index each port must show. A design that did not restart grouping on a change, or that kept the first sample of a group instead of the last, would show indices that are off by one or more. A design that swapped the demultiplexer order would put the newer index on B. A stream with gaps catches a phase counter that advances on idle clocks. Timing the edges of dclk_o catches a slow-rate clock built only from rising edges, since its high and low times would differ by a full period.

// File: rtl/spr_pkg.sv
`timescale 1ns/1ps
package spr_pkg;
   typedef struct packed {
      logic div;
      logic mod;
      logic dup;
   } spr_mode_t;

   function automatic logic b_live(spr_mode_t m);
      return m.dup | (m.div & ~m.mod);
   endfunction

   function automatic logic is_pair(spr_mode_t m);
      return m.div & ~m.mod & ~m.dup;
   endfunction
endpackage

// File: rtl/spr_phase.sv
`timescale 1ns/1ps
module spr_phase #(
   parameter int DEC = 5,
   localparam int PW = $clog2(DEC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  spr_pkg::spr_mode_t mode,
   output logic [PW-1:0]     ph,
   output logic              done
);
   logic [PW-1:0] lim;

   always_comb begin
      if (!mode.div)     lim = '0;
      else if (mode.mod) lim = PW'(DEC - 1);
      else               lim = PW'(1);
   end

   assign done = adv && (ph == lim);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) ph <= '0;
      else if (adv)      ph <= (ph == lim) ? '0 : ph + PW'(1);
   end
endmodule

// File: rtl/spr_steer.sv
`timescale 1ns/1ps
module spr_steer #(
   parameter int W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              done,
   input  spr_pkg::spr_mode_t mode,
   input  logic [W-1:0]      din,
   output logic [W-1:0]      a_q,
   output logic [W-1:0]      b_q
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         prev_q <= '0;
      end else begin
         if (take) prev_q <= din;
         if (done) begin
            a_q <= din;
            if (mode.dup)                   b_q <= din;
            else if (spr_pkg::is_pair(mode)) b_q <= prev_q;
         end
      end
   end
endmodule

// File: rtl/spr_dclk.sv
`timescale 1ns/1ps
module spr_dclk #(
   parameter int N  = 2,
   parameter int PW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   input  logic [PW-1:0] ph,
   output logic          dclk
);
   localparam int HOLD = N / 2;
   localparam bit ODD  = (N % 2) == 1;

   logic early;
   logic q_pos;

   if (HOLD > 1) begin : g_early
      assign early = ph < PW'(HOLD - 1);
   end else begin : g_no_early
      assign early = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) q_pos <= 1'b0;
      else if (adv)      q_pos <= (ph == PW'(N - 1)) || early;
   end

   if (ODD) begin : g_odd
      logic q_neg;
      always_ff @(negedge clk) begin
         if (!rst_n) q_neg <= 1'b0;
         else        q_neg <= q_pos;
      end
      assign dclk = q_pos | q_neg;
   end else begin : g_even
      assign dclk = q_pos;
   end
endmodule

// File: rtl/sample_port_router.sv
`timescale 1ns/1ps
module sample_port_router #(
   parameter int SAMPLE_W = 8,
   parameter int DEC_SLOW = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] smp_i,
   input  logic                smp_vld_i,
   input  logic                cfg_div_i,
   input  logic                cfg_mod_i,
   input  logic                cfg_dup_i,
   output logic [SAMPLE_W-1:0] port_a_o,
   output logic [SAMPLE_W-1:0] port_b_o,
   output logic                a_act_o,
   output logic                b_act_o,
   output logic                dclk_o
);
   import spr_pkg::*;
   localparam int PW = $clog2(DEC_SLOW);

   if (SAMPLE_W < 1 || DEC_SLOW < 3) begin : g_param_bad
      $error("sample_port_router: SAMPLE_W must be >= 1 and DEC_SLOW >= 3");
   end

   spr_mode_t     pins, mode_q;
   logic          primed_q, run_q, b_act_q;
   logic          chg, adv, done;
   logic [PW-1:0] ph;
   logic          d_half, d_slow;

   assign pins = '{div: cfg_div_i, mod: cfg_mod_i, dup: cfg_dup_i};
   assign chg  = !primed_q || (pins != mode_q);
   assign adv  = smp_vld_i && !chg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= '0;
         primed_q <= 1'b0;
         run_q    <= 1'b0;
         b_act_q  <= 1'b0;
      end else begin
         mode_q   <= pins;
         primed_q <= 1'b1;
         run_q    <= 1'b1;
         b_act_q  <= b_live(pins);
      end
   end

   spr_phase #(.DEC(DEC_SLOW)) i_phase (
      .clk(clk), .rst_n(rst_n), .clr(chg), .adv(adv),
      .mode(mode_q), .ph(ph), .done(done)
   );

   spr_steer #(.W(SAMPLE_W)) i_steer (
      .clk(clk), .rst_n(rst_n), .take(adv), .done(done),
      .mode(mode_q), .din(smp_i), .a_q(port_a_o), .b_q(port_b_o)
   );

   spr_dclk #(.N(2), .PW(PW)) i_dclk_half (
      .clk(clk), .rst_n(rst_n), .clr(chg), .adv(adv), .ph(ph), .dclk(d_half)
   );

   spr_dclk #(.N(DEC_SLOW), .PW(PW)) i_dclk_slow (
      .clk(clk), .rst_n(rst_n), .clr(chg), .adv(adv), .ph(ph), .dclk(d_slow)
   );

   assign dclk_o  = run_q & (mode_q.div ? (mode_q.mod ? d_slow : d_half) : clk);
   assign a_act_o = run_q;
   assign b_act_o = b_act_q;
endmodule

// File: rtl/sample_port_router_chk.sv
`timescale 1ns/1ps
module sample_port_router_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cfg_div_i,
   input logic         cfg_mod_i,
   input logic         cfg_dup_i,
   input logic [W-1:0] port_a_o,
   input logic [W-1:0] port_b_o,
   input logic         a_act_o,
   input logic         b_act_o,
   input logic         dclk_o
);
   // R1
   dclk_rst_chk: assert property (@(posedge clk) !rst_n |-> !dclk_o);

   // R8
   a_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> a_act_o);

   // R8
   b_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> b_act_o == $past(cfg_dup_i | (cfg_div_i & ~cfg_mod_i)));

   // R8
   b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !b_act_o |=> $stable(port_b_o));

   // R3 R5 R7
   dup_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(port_b_o) && $past(cfg_dup_i, 2)) |-> port_a_o == port_b_o);

   // R11
   dclk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(port_a_o) && $past(cfg_div_i) && $past(cfg_div_i, 2)) |-> dclk_o);
endmodule

bind sample_port_router sample_port_router_chk #(.W(SAMPLE_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_div_i(cfg_div_i), .cfg_mod_i(cfg_mod_i),
   .cfg_dup_i(cfg_dup_i), .port_a_o(port_a_o), .port_b_o(port_b_o),
   .a_act_o(a_act_o), .b_act_o(b_act_o), .dclk_o(dclk_o)
);

// File: tb/test_sample_port_router.sv
`timescale 1ns/1ps
module test_sample_port_router;
   localparam int CLK_P = 10;
   localparam int W     = 8;
   localparam int DEC   = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] smp = '0;
   logic         vld = 1'b0;
   logic         cdiv = 1'b0, cmod = 1'b0, cdup = 1'b0;
   logic [W-1:0] pa, pb;
   logic         aact, bact, dclk;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   logic [W-1:0] expa = '0, expb = '0, prevs = '0, cur = '0;

   always #(CLK_P/2) clk = ~clk;

   sample_port_router #(.SAMPLE_W(W), .DEC_SLOW(DEC)) i_sample_port_router (
      .clk(clk), .rst_n(rst_n), .smp_i(smp), .smp_vld_i(vld),
      .cfg_div_i(cdiv), .cfg_mod_i(cmod), .cfg_dup_i(cdup),
      .port_a_o(pa), .port_b_o(pb), .a_act_o(aact), .b_act_o(bact), .dclk_o(dclk)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_mode(input bit dv, input bit md, input bit dp, input int cyc, input bit gaps);
      int n;
      int k;
      bit first;
      bit upd;
      string tag;
      logic [W-1:0] s;
      bit v;
      n = dv ? (md ? DEC : 2) : 1;
      if (!dv)     tag = dp ? "R3" : "R2";
      else if (!md) tag = dp ? "R5" : "R4";
      else          tag = dp ? "R7" : "R6";
      if (gaps) tag = "R12";
      cdiv = dv; cmod = md; cdup = dp;
      k = 0; first = 1;
      for (int c = 0; c < cyc; c++) begin
         @(posedge clk);
         s = cur; v = vld; upd = 0;
         if (first) first = 0;
         else if (v) begin
            k++;
            if (k % n == 0) begin
               expa = s;
               if (dp) expb = s;
               else if (dv && !md) expb = prevs;
               upd = 1;
            end
            prevs = s;
         end
         #3;
         chk(pa == expa, (k < n) ? "R9" : tag, pa, expa);
         chk(pb == expb, (k < n) ? "R9" : tag, pb, expb);
         chk(aact == 1'b1, "R8", aact, 1);
         chk(bact == (dp | (dv & ~md)), "R8", bact, dp | (dv & ~md));
         if (!gaps && dv && k > n && v) begin
            if (upd) chk(dclk == 1'b1, "R11", dclk, 1);
            else if (md && (k % n == 3)) chk(dclk == 1'b0, "R11", dclk, 0);
            else if (!md) chk(dclk == 1'b0, "R11", dclk, 0);
         end
         @(negedge clk);
         cur = cur + 1'b1;
         smp = cur;
         vld = gaps ? ((c % 3) != 1) : 1'b1;
      end
   endtask

   task automatic measure(input bit dv, input bit md, input real hi, input real lo);
      realtime t0, t1, t2;
      cdiv = dv; cmod = md; cdup = 1'b0; vld = 1'b1;
      repeat (12) @(negedge clk);
      @(posedge dclk); t0 = $realtime;
      @(negedge dclk); t1 = $realtime;
      @(posedge dclk); t2 = $realtime;
      chk((t1 - t0) > hi - 0.01 && (t1 - t0) < hi + 0.01, "R10", int'(t1 - t0), int'(hi));
      chk((t2 - t1) > lo - 0.01 && (t2 - t1) < lo + 0.01, "R10", int'(t2 - t1), int'(lo));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(pa == '0, "R1", pa, 0);
      chk(pb == '0, "R1", pb, 0);
      chk(aact == 1'b0 && bact == 1'b0, "R1", {aact, bact}, 0);
      chk(dclk == 1'b0, "R1", dclk, 0);
      rst_n = 1'b1;
      vld = 1'b1;
      run_mode(0, 0, 0, 12, 0);
      run_mode(0, 0, 1, 12, 0);
      run_mode(1, 0, 0, 20, 0);
      run_mode(1, 0, 1, 20, 0);
      run_mode(1, 1, 0, 30, 0);
      run_mode(1, 1, 1, 30, 0);
      run_mode(0, 1, 0, 12, 0);
      run_mode(1, 0, 0, 24, 1);
      run_mode(0, 1, 1, 12, 0);
      run_mode(1, 1, 0, 30, 1);
      measure(1, 0, real'(CLK_P), real'(CLK_P));
      measure(1, 1, real'(CLK_P) * DEC / 2.0, real'(CLK_P) * DEC / 2.0);
      measure(0, 0, real'(CLK_P) / 2.0, real'(CLK_P) / 2.0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule